// File: doc/BRIEF.md
# Supply Supervisor Reset Generator

This block generates the system reset for a processor from two causes. The first is a digital supply-good flag that an external threshold comparator produces. The second is an active-low manual reset line, which may come from a pushbutton. While either cause is present, reset is asserted. Once both causes have cleared, reset stays asserted for a fixed stretch of clock cycles and is then released. Any new cause that appears during that stretch starts the full stretch again, measured from the moment the cause goes away. The same stretched pulse absorbs the contact bounce of a mechanical switch, so the block needs no separate debounce logic.

The manual reset line is asynchronous to the clock, so it passes through a synchronizer chain before it is used. The supply-good flag is taken as already synchronous. Both polarities of reset are driven from one internal flag, so they can never disagree. The hold length is the parameter `HOLD_CYCLES`. Its default is sized for roughly 200 ms at a 100 MHz clock, and simulation uses a small value such as 16.

Top module: `supv_reset_gen`

## Requirements
- R1: When `supply_ok` is sampled low at a clock edge, `rst_hi` is 1 after that edge, and it stays 1 for as long as `supply_ok` remains low.
- R2: Once no cause is sampled any more, `rst_hi` falls exactly at the `HOLD_CYCLES`-th clock edge after the last edge that sampled a cause, and not earlier.
- R3: A return of `supply_ok` to 0 at any point of the hold stretch, including its final cycle, restarts the full `HOLD_CYCLES` stretch, counted from the last edge that sees the supply low.
- R4: With the default two-stage synchronizer, `mr_n` sampled low at edge e asserts `rst_hi` after edge e+2. Holding `mr_n` low keeps reset asserted. After `mr_n` returns high, the hold stretch counts from the last edge at which the synchronized level was still low.
- R5: A `mr_n` low pulse that lasts for only one clock edge is enough to start a full reset.
- R6: `rst_lo_n` is at every moment the logical inverse of `rst_hi`.
- R7: While the synchronous active-high `rst` is 1, `rst_hi` is 1 and the hold counter is loaded. After `rst` falls with no cause present, `rst_hi` falls at the `HOLD_CYCLES`-th edge.
- R8: A bouncing `mr_n` (alternating low and high samples) keeps extending reset, and release comes `HOLD_CYCLES` edges after the last synchronized low sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high initialisation |
| supply_ok | input | 1 | 1 when the supply is above threshold |
| mr_n | input | 1 | Asynchronous active-low manual reset request |
| rst_hi | output | 1 | Active-high reset output |
| rst_lo_n | output | 1 | Active-low reset output |

## Verification
The supply flag is stimulated in four ways, each of which separates a different failure:
- a clean drop, which checks the one-edge assertion latency;
- a long low period, which checks that reset is held;
- a dip early in the hold stretch, which checks the restart point;
- a dip in the final hold cycle, where the counter already stands at zero, which catches an off-by-one restart.

The manual line is also stimulated in four ways:
- a single-edge pulse, which shows that a short trigger is not lost in the synchronizer;
- a long hold, which places the release count after synchronizer latency;
- a low-high-low bounce, which shows that a late synchronized low sample extends the pulse instead of being ignored;
- a check made one edge after the line drops, which confirms that reset has not yet asserted.

Every sample checks the exact release edge and the complementary output.

// File: rtl/supv_pkg.sv
package supv_pkg;

    // Reasons for holding reset, as seen by the hold logic.
    typedef struct packed {
        logic supply_low;
        logic manual;
    } cause_t;

    // Phase of the hold logic.
    typedef enum logic [1:0] {
        PH_CAUSE = 2'd0,
        PH_HOLD  = 2'd1,
        PH_IDLE  = 2'd2
    } phase_t;

    // Pair of reset outputs driven from one flag.
    typedef struct packed {
        logic hi;
        logic lo_n;
    } rst_pair_t;

    function automatic logic any_cause(cause_t c);
        return c.supply_low | c.manual;
    endfunction

    function automatic rst_pair_t make_pair(logic active);
        rst_pair_t p;
        p.hi   = active;
        p.lo_n = ~active;
        return p;
    endfunction

    // Counter width for a given hold length, never below one bit.
    function automatic int unsigned cnt_width(int unsigned hold);
        return (hold > 1) ? $clog2(hold) : 1;
    endfunction

endpackage

// File: rtl/supv_sync.sv
module supv_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= RST_VAL;
                else     chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= {STAGES{RST_VAL}};
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/supv_hold_ctr.sv
module supv_hold_ctr
    import supv_pkg::*;
#(
    parameter int unsigned HOLD_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic cause,
    output logic active
);
    localparam int unsigned CNT_W = cnt_width(HOLD_CYCLES);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(HOLD_CYCLES - 1);

    phase_t           phase;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_CAUSE;
            cnt   <= LOAD;
        end else if (cause) begin
            phase <= PH_CAUSE;
            cnt   <= LOAD;
        end else begin
            case (phase)
                PH_CAUSE, PH_HOLD: begin
                    if (cnt == '0) begin
                        phase <= PH_IDLE;
                    end else begin
                        phase <= PH_HOLD;
                        cnt   <= cnt - 1'b1;
                    end
                end
                default: begin
                    phase <= PH_IDLE;
                end
            endcase
        end
    end

    assign active = (phase != PH_IDLE);
endmodule

// File: rtl/supv_out_stage.sv
module supv_out_stage
    import supv_pkg::*;
(
    input  logic active,
    output logic rst_hi,
    output logic rst_lo_n
);
    rst_pair_t pair;

    always_comb begin
        pair = make_pair(active);
    end

    assign rst_hi   = pair.hi;
    assign rst_lo_n = pair.lo_n;
endmodule

// File: rtl/supv_reset_gen.sv
module supv_reset_gen
    import supv_pkg::*;
#(
    parameter int unsigned HOLD_CYCLES = 20_000_000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic supply_ok,
    input  logic mr_n,
    output logic rst_hi,
    output logic rst_lo_n
);
    logic   mr_n_sync;
    cause_t causes;
    logic   hold_cause;
    logic   hold_active;

    supv_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) u_mr_sync (
        .clk (clk),
        .rst (rst),
        .d   (mr_n),
        .q   (mr_n_sync)
    );

    always_comb begin
        causes.supply_low = ~supply_ok;
        causes.manual     = ~mr_n_sync;
        hold_cause        = any_cause(causes);
    end

    supv_hold_ctr #(
        .HOLD_CYCLES (HOLD_CYCLES)
    ) u_hold (
        .clk    (clk),
        .rst    (rst),
        .cause  (hold_cause),
        .active (hold_active)
    );

    supv_out_stage u_out (
        .active   (hold_active),
        .rst_hi   (rst_hi),
        .rst_lo_n (rst_lo_n)
    );
endmodule

// File: rtl/supv_reset_chk.sv
module supv_reset_chk #(
    parameter int unsigned HOLD_CYCLES = 16
) (
    input logic clk,
    input logic rst,
    input logic supply_ok,
    input logic mr_n,
    input logic cause,
    input logic rst_hi,
    input logic rst_lo_n
);
    localparam int unsigned QW = $clog2(HOLD_CYCLES + 2);
    localparam logic [QW-1:0] QMAX = QW'(HOLD_CYCLES);

    // Edges since the hold logic last saw a cause, saturating at HOLD_CYCLES.
    logic [QW-1:0] quiet;

    always_ff @(posedge clk) begin
        if (rst || cause)     quiet <= '0;
        else if (quiet != QMAX) quiet <= quiet + 1'b1;
    end

    assert_complement_R6: assert property (@(posedge clk)
        disable iff (rst) rst_lo_n == !rst_hi);

    assert_supply_low_R1: assert property (@(posedge clk)
        disable iff (rst) !supply_ok |=> rst_hi);

    assert_manual_latency_R4: assert property (@(posedge clk)
        disable iff (rst) !mr_n |-> ##3 rst_hi);

    assert_hold_kept_R2: assert property (@(posedge clk)
        disable iff (rst) (quiet < QMAX) |-> rst_hi);

    assert_release_R2: assert property (@(posedge clk)
        disable iff (rst) (quiet == QMAX) |-> !rst_hi);

    assert_restart_R3: assert property (@(posedge clk)
        disable iff (rst) cause |=> rst_hi);
endmodule

bind supv_reset_gen supv_reset_chk #(
    .HOLD_CYCLES (HOLD_CYCLES)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .supply_ok (supply_ok),
    .mr_n      (mr_n),
    .cause     (hold_cause),
    .rst_hi    (rst_hi),
    .rst_lo_n  (rst_lo_n)
);

// File: tb/test_supv_reset_gen.sv
module test_supv_reset_gen;
    localparam int unsigned HOLD = 16;
    localparam int NVEC = 31;

    typedef struct packed {
        logic       sup;
        logic       mr;
        logic [7:0] n;
        logic       ex;
        logic [3:0] req;
    } vec_t;

    // Fields: supply_ok, mr_n, edges to run, expected rst_hi, requirement.
    localparam vec_t VEC [NVEC] = '{
        {1'b1, 1'b1, 8'd15, 1'b1, 4'd2},  // R2 hold after init release
        {1'b1, 1'b1, 8'd1,  1'b0, 4'd2},  // R2 release edge
        {1'b0, 1'b1, 8'd1,  1'b1, 4'd1},  // R1 one-edge assert
        {1'b0, 1'b1, 8'd20, 1'b1, 4'd1},  // R1 held while low
        {1'b1, 1'b1, 8'd15, 1'b1, 4'd2},
        {1'b1, 1'b1, 8'd1,  1'b0, 4'd2},
        {1'b0, 1'b1, 8'd1,  1'b1, 4'd3},  // R3 early dip
        {1'b1, 1'b1, 8'd8,  1'b1, 4'd3},
        {1'b0, 1'b1, 8'd2,  1'b1, 4'd3},
        {1'b1, 1'b1, 8'd15, 1'b1, 4'd3},
        {1'b1, 1'b1, 8'd1,  1'b0, 4'd3},
        {1'b1, 1'b0, 8'd1,  1'b0, 4'd4},  // R4 not yet through synchronizer
        {1'b1, 1'b1, 8'd1,  1'b0, 4'd5},  // R5 single-edge pulse
        {1'b1, 1'b1, 8'd1,  1'b1, 4'd5},
        {1'b1, 1'b1, 8'd15, 1'b1, 4'd5},
        {1'b1, 1'b1, 8'd1,  1'b0, 4'd5},
        {1'b1, 1'b0, 8'd30, 1'b1, 4'd4},  // R4 held low
        {1'b1, 1'b1, 8'd17, 1'b1, 4'd4},
        {1'b1, 1'b1, 8'd1,  1'b0, 4'd4},
        {1'b1, 1'b0, 8'd1,  1'b0, 4'd8},  // R8 bounce
        {1'b1, 1'b1, 8'd1,  1'b0, 4'd8},
        {1'b1, 1'b0, 8'd1,  1'b1, 4'd8},
        {1'b1, 1'b1, 8'd1,  1'b1, 4'd8},
        {1'b1, 1'b1, 8'd1,  1'b1, 4'd8},
        {1'b1, 1'b1, 8'd15, 1'b1, 4'd8},
        {1'b1, 1'b1, 8'd1,  1'b0, 4'd8},
        {1'b0, 1'b1, 8'd1,  1'b1, 4'd3},  // R3 dip in final hold cycle
        {1'b1, 1'b1, 8'd15, 1'b1, 4'd3},
        {1'b0, 1'b1, 8'd1,  1'b1, 4'd3},
        {1'b1, 1'b1, 8'd15, 1'b1, 4'd3},
        {1'b1, 1'b1, 8'd1,  1'b0, 4'd3}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic supply_ok = 1'b1;
    logic mr_n = 1'b1;
    logic rst_hi;
    logic rst_lo_n;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    supv_reset_gen #(
        .HOLD_CYCLES (HOLD),
        .SYNC_STAGES (2)
    ) i_supv_reset_gen (
        .clk       (clk),
        .rst       (rst),
        .supply_ok (supply_ok),
        .mr_n      (mr_n),
        .rst_hi    (rst_hi),
        .rst_lo_n  (rst_lo_n)
    );

    task automatic check_out(input logic exp, input int req, input string what);
        n_chk++;
        if (rst_hi !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: rst_hi=%b expected %b", req, what, rst_hi, exp);
        end
        n_chk++;
        if (rst_lo_n !== ~exp) begin  // R6 complement
            n_fail++;
            $display("FAIL R6 %s: rst_lo_n=%b expected %b", what, rst_lo_n, ~exp);
        end
    endtask

    task automatic run_edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        // R7 reset state
        run_edges(3);
        check_out(1'b1, 7, "during init");
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            supply_ok = VEC[i].sup;
            mr_n      = VEC[i].mr;
            run_edges(int'(VEC[i].n));
            check_out(VEC[i].ex, int'(VEC[i].req), $sformatf("vector %0d", i));
        end

        // R7 init while released, then full hold after release
        rst = 1'b1;
        run_edges(1);
        check_out(1'b1, 7, "init reasserts");
        rst = 1'b0;
        run_edges(15);
        check_out(1'b1, 7, "hold after init");
        run_edges(1);
        check_out(1'b0, 7, "release after init");

        // R7 manual low during init is overridden by the loaded hold
        mr_n = 1'b0;
        rst = 1'b1;
        run_edges(2);
        check_out(1'b1, 7, "init with manual low");
        mr_n = 1'b1;
        rst = 1'b0;
        run_edges(15);
        check_out(1'b1, 7, "hold after init with manual");
        run_edges(1);
        check_out(1'b0, 7, "release after init with manual");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(8 * 20000);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule